// File: doc/BRIEF.md
# Address-Bit Scanline Interrupt Counter

This block counts rising edges on bit 12 of the video address bus and raises an interrupt to the CPU when a programmable count runs out. A video processor fetching from both pattern tables toggles that bit a fixed number of times per line. Counting its rising edges therefore gives a line counter without a separate line signal. Any change of the address counts, whether or not a memory access goes with it. For that reason the block has no read or write strobe input.

A low-time filter rejects edges that come too soon after the bit last went low. The filter counts falling edges of the CPU-side M2 clock while bit 12 is low, and a rising edge counts only once that count has reached `FILTER_EDGES`. Software reaches the block through a small register port. It writes a reload value, requests a reload, acknowledges the interrupt and enables it. The interrupt output is active low and stays asserted until it is acknowledged.

The register port is a plain strobed write and has no valid/ready pair. It cannot stall, so the writer needs no back-pressure. All inputs are sampled on `clk`, and `m2` and `a12` are treated as synchronous levels.

Top module: `a12_irq_counter`

## Requirements
- R1: Reset (`rst_n` low) clears all state. The interrupt is disabled, `irq_n` is 1, the counter and the reload value are 0, no reload is pending and the filter is empty. After reset, edges alone never bring `irq_n` low until software writes the enable register.
- R2: A rising edge of `a12` is counted only if, before it, `a12` was sampled low across at least `FILTER_EDGES` falling edges of `m2` (default 3). A falling edge is `m2` sampled 1 on one cycle and 0 on the next.
- R3: A rising edge that follows a low time shorter than the filter window produces no count. A level that stays high produces no count either.
- R4: A write to the reload register does not change the counter. It marks a reload as pending, and the next counted edge loads the counter from the reload value as it is at that edge.
- R5: On a counted edge with no reload pending and a non-zero counter, the counter decrements by one. When the value after the update is 0 and the interrupt is enabled, `irq_n` is low from that same clock edge.
- R6: A write to the acknowledge register (select 2) clears a pending interrupt and disables the interrupt. A write to the enable register (select 3) enables it again. While the interrupt is disabled, counted edges still update the counter.
- R7: Once `irq_n` is low, it stays low through any further counted edges until an acknowledge write.
- R8: Register select codes are 0 for the reload value (taken from `wr_data`), 1 for a reload request, 2 for acknowledge/disable and 3 for enable. `wr_data` is ignored for selects 1 to 3.
- R9: A counted edge that finds the counter at 0 reloads it. With a reload value of 0, every counted edge leaves 0 and so raises the interrupt when it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | CPU-side M2 clock level, timebase for the low-time filter |
| a12 | input | 1 | Video address bus bit 12 level |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select (0 reload value, 1 reload request, 2 acknowledge, 3 enable) |
| wr_data | input | CNT_W | Write data, used only by select 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with `CNT_W` = 8 and `FILTER_EDGES` = 3. It drives `m2` with a period of six system clocks. A one-cycle low pulse on `a12` then fits at most one M2 falling edge, and a thirty-cycle low time always fills the filter. Both the rejected-edge and the accepted-edge paths are therefore exercised. With an 8-bit reload value, small counts of zero to three reach the reload, the decrement, the zero-reload and the repeated-interrupt cases within a few dozen edges. The bench also checks that a reload request does not load immediately.

// File: rtl/a12_irq_pkg.sv
package a12_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD_VAL = 2'd0,
    SEL_RELOAD_REQ = 2'd1,
    SEL_IRQ_ACK    = 2'd2,
    SEL_IRQ_EN     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int FILTER_EDGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  input  logic a12,
  output logic tick
);
  localparam int LW = (FILTER_EDGES < 1) ? 1 : $clog2(FILTER_EDGES + 1);
  localparam logic [LW-1:0] FULL = LW'(FILTER_EDGES);

  logic          a12_q;
  logic          m2_q;
  logic [LW-1:0] low_cnt;
  logic          m2_fall;
  logic          armed;

  assign m2_fall = m2_q & ~m2;

  generate
    if (FILTER_EDGES == 0) begin : g_nofilter
      assign armed = 1'b1;
    end else begin : g_filter
      assign armed = (low_cnt == FULL);
    end
  endgenerate

  assign tick = a12 & ~a12_q & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a12_q   <= 1'b0;
      m2_q    <= 1'b0;
      low_cnt <= '0;
    end else begin
      a12_q <= a12;
      m2_q  <= m2;
      if (a12) begin
        low_cnt <= '0;
      end else if (m2_fall && (low_cnt != FULL)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter
  import a12_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq_pend
);
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_nxt;
  logic             reload_pend;
  logic             irq_en;

  always_comb begin
    if ((count == '0) || reload_pend) begin
      count_nxt = reload_val;
    end else begin
      count_nxt = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val  <= '0;
      count       <= '0;
      reload_pend <= 1'b0;
      irq_en      <= 1'b0;
      irq_pend    <= 1'b0;
    end else begin
      if (tick) begin
        count       <= count_nxt;
        reload_pend <= 1'b0;
        if ((count_nxt == '0) && irq_en) begin
          irq_pend <= 1'b1;
        end
      end
      if (wr_en) begin
        unique case (wr_sel)
          SEL_RELOAD_VAL: reload_val <= wr_data;
          SEL_RELOAD_REQ: reload_pend <= 1'b1;
          SEL_IRQ_ACK: begin
            irq_en   <= 1'b0;
            irq_pend <= 1'b0;
          end
          SEL_IRQ_EN: irq_en <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/a12_irq_counter.sv
module a12_irq_counter
  import a12_irq_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int FILTER_EDGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m2,
  input  logic             a12,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq_n
);
  logic     cnt_tick;
  logic     irq_pend;
  reg_sel_e sel_dec;

  assign sel_dec = reg_sel_e'(wr_sel);

  a12_edge_filter #(.FILTER_EDGES(FILTER_EDGES)) u_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .m2    (m2),
    .a12   (a12),
    .tick  (cnt_tick)
  );

  irq_down_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_tick),
    .wr_en    (wr_en),
    .wr_sel   (sel_dec),
    .wr_data  (wr_data),
    .irq_pend (irq_pend)
  );

  assign irq_n = ~irq_pend;
endmodule

// File: rtl/a12_irq_counter_chk.sv
module a12_irq_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a12,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       irq_n,
  input logic       tick
);
  logic ack_wr;
  assign ack_wr = wr_en && (wr_sel == 2'd2);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> irq_n);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !ack_wr) |=> !irq_n);

  assert_irq_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(tick));

  assert_tick_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (a12 && !$past(a12)));

  assert_tick_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (!$past(a12, 2) && !$past(a12, 3)));
endmodule

bind a12_irq_counter a12_irq_counter_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a12    (a12),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .irq_n  (irq_n),
  .tick   (cnt_tick)
);

// File: tb/a12_irq_counter_bench.sv
module a12_irq_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int FILT       = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             m2 = 1'b0;
  logic             a12 = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             irq_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  a12_irq_counter #(.CNT_W(CNT_W), .FILTER_EDGES(FILT)) u_a12_irq_counter (
    .clk(clk), .rst_n(rst_n), .m2(m2), .a12(a12),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // M2 runs at one sixth of the system clock
  int m2_div = 0;
  always @(negedge clk) begin
    m2_div = m2_div + 1;
    if (m2_div == 3) begin
      m2_div = 0;
      m2 = ~m2;
    end
  end

  // behavioural reference
  int  md_low = 0, md_cnt = 0, md_latch = 0;
  bit  md_a12p = 0, md_m2p = 0, md_pend = 0, md_en = 0, md_irq = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      md_low = 0; md_cnt = 0; md_latch = 0;
      md_a12p = 0; md_m2p = 0; md_pend = 0; md_en = 0; md_irq = 0;
    end else begin
      bit counted;
      counted = a12 && !md_a12p && (md_low >= FILT);
      if (counted) begin
        if (md_cnt == 0 || md_pend) md_cnt = md_latch;
        else md_cnt = md_cnt - 1;
        md_pend = 0;
        if (md_cnt == 0 && md_en) md_irq = 1;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: md_latch = int'(wr_data);
          2'd1: md_pend = 1;
          2'd2: begin md_en = 0; md_irq = 0; end
          default: md_en = 1;
        endcase
      end
      if (a12) md_low = 0;
      else if (md_m2p && !m2 && md_low < FILT) md_low = md_low + 1;
      md_a12p = a12;
      md_m2p  = m2;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors = vectors + 1;
      if (irq_n !== !md_irq) begin
        fails = fails + 1;
        $display("FAIL R7 per-cycle irq_n actual=%b expected=%b at %0t", irq_n, !md_irq, $time);
      end
    end
  end

  task automatic chk(input logic exp, input string req);
    vectors = vectors + 1;
    if (irq_n !== exp) begin
      fails = fails + 1;
      $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a12 = v;
    end
  endtask

  task automatic long_pulse();
    hold(1'b0, 30);
    hold(1'b1, 4);
  endtask

  task automatic short_pulse();
    hold(1'b0, 1);
    hold(1'b1, 4);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CNT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails = fails + 1;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(1'b1, "R1 reset");
    rst_n = 1'b1;
    // R5: reload 2, count down to zero
    wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd3, 8'd0);
    long_pulse(); chk(1'b1, "R5 after load");
    long_pulse(); chk(1'b1, "R5 at one");
    long_pulse(); chk(1'b0, "R5 reaches zero");
    long_pulse(); chk(1'b0, "R7 sticky");
    // R6 acknowledge and disable
    wr(2'd2, 8'd0); chk(1'b1, "R6 ack");
    long_pulse(); long_pulse(); chk(1'b1, "R6 disabled at zero");
    wr(2'd3, 8'd0);
    long_pulse(); long_pulse();
    // R3 short low pulses are not counted
    short_pulse(); short_pulse(); short_pulse(); chk(1'b1, "R3 short pulses");
    hold(1'b1, 10); chk(1'b1, "R3 steady high");
    long_pulse(); chk(1'b0, "R2 filtered edge counts");
    // R4 reload is deferred
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    wr(2'd0, 8'd3); wr(2'd1, 8'd0); long_pulse();
    wr(2'd0, 8'd1); wr(2'd1, 8'd0);
    chk(1'b1, "R4 no immediate load");
    long_pulse(); chk(1'b1, "R4 loaded at edge");
    long_pulse(); chk(1'b0, "R4 count from new value");
    // R9 zero reload value
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    wr(2'd0, 8'd0); wr(2'd1, 8'd0);
    long_pulse(); chk(1'b0, "R9 zero reload");
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    long_pulse(); chk(1'b0, "R9 repeat");
    // R8 data ignored on control selects
    wr(2'd2, 8'hFF); wr(2'd3, 8'h05); wr(2'd1, 8'h07);
    long_pulse(); chk(1'b0, "R8 data ignored");
    // R1 reset mid-operation
    @(negedge clk); rst_n = 1'b0; a12 = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b1, "R1 reset clears");
    rst_n = 1'b1;
    long_pulse(); long_pulse(); chk(1'b1, "R1 disabled after reset");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule